// File: doc/BRIEF.md
# UART receiver with extended error flags

This block recovers asynchronous serial characters from a single receive line using an enable pulse at sixteen times the bit rate. A character opens with a low start bit. Data follows least significant bit first, as either eight bits or nine bits, and a high stop bit closes it. The received byte is held on an output register. A ninth-bit output carries data bit 8 in nine-bit mode and the sampled stop-bit level in eight-bit mode. A receive-complete flag tells software that a character is waiting.

Two behaviours are selectable. In legacy behaviour, a character that finishes while the receive-complete flag is still high is dropped. In eight-bit mode with the multiprocessor input set, a character whose stop bit is missing is also dropped. With the extended enable set, every character is stored. Three more flags then report what went wrong: a missing stop bit, a line held low for longer than a whole nine-bit character (a break), and a character that replaced one software had not yet collected.

Top module: `uartx_rx`

## Requirements
- R1: After reset, every output is 0.
- R2: The line passes through two synchronizing flops. A start is accepted only on a low level that follows a high level seen on an oversample tick. The low level must still be present 8 ticks after detection. If it is not, the receiver returns to idle and no output changes.
- R3: Data bits are stored LSB first. Each bit is the majority of the samples taken at ticks 7, 8 and 9 of its bit period, so one corrupted sample does not change the bit.
- R4: The receive-complete flag rises in the cycle of the stop-bit majority decision. A pulse on the software clear input lowers it. A completion in the same cycle takes priority over the clear.
- R5: In nine-bit mode, the ninth-bit output carries data bit 8. In eight-bit mode, it carries the sampled stop-bit level.
- R6: With the extended enable low, a character that completes while the receive-complete flag is high leaves the outputs unchanged. In eight-bit mode with the multiprocessor input high, a character with a low stop bit is also discarded.
- R7: With the extended enable high, every character is stored. The frame error flag is then set to the inverse of the stop-bit level, in both eight-bit and nine-bit modes.
- R8: With the extended enable high, a character that completes while the receive-complete flag is high sets the overwrite flag. A read strobe clears the overwrite flag but leaves the receive-complete flag unchanged.
- R9: With the extended enable high, the break flag rises after 177 consecutive low ticks, which is longer than 11 bit periods. The next stored character clears it. After a break, no new start is taken until the line has gone high.
- R10: While the extended enable is low, the frame error, break and overwrite flags are held at 0.
- R11: Sampling and counting advance only on cycles with the tick input high. At half tick rate, a character stretched to twice the length is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversample enable, 16 per bit period |
| nine_bit_i | input | 1 | 1: nine data bits, 0: eight |
| mp_i | input | 1 | Legacy eight-bit: drop characters with a low stop bit |
| ext_en_i | input | 1 | Enables the extended receive behaviour and error flags |
| rxf_clr_i | input | 1 | Software clear of the receive-complete flag |
| rd_i | input | 1 | Data-read strobe, clears the overwrite flag |
| data_o | output | 8 | Received byte |
| bit9_o | output | 1 | Data bit 8 or the stop-bit level |
| rxf_o | output | 1 | Receive-complete flag |
| ferr_o | output | 1 | Frame error flag |
| berr_o | output | 1 | Break flag |
| oerr_o | output | 1 | Overwrite flag |

## Verification
The assertions assume that the mode inputs, nine-bit and multiprocessor, stay constant while a character is in flight. They also assume that the read strobe is not applied on a tick cycle when an overwrite check depends on it. The stimulus changes modes only while the line idles high, after the previous character has completed. It raises the clear and read strobes only in idle gaps between characters. The tick input is either constant high, alternating, or held low for a whole stretch, and never changes in the middle of a bit.

// File: rtl/uartx_pkg.sv
`timescale 1ns/1ps
package uartx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2
    } rx_state_e;

    // Two-of-three vote for mid-bit sampling
    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uartx_sync2.sv
`timescale 1ns/1ps
module uartx_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic s1_q, s2_q;
    logic s1_d, s2_d;

    always_comb begin
        s1_d = d_i;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/uartx_brk_det.sv
`timescale 1ns/1ps
module uartx_brk_det #(
    parameter int BRK_TICKS = 176
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    output logic hit_o
);
    localparam int BW = $clog2(BRK_TICKS + 2);

    logic [BW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        hit_o = 1'b0;
        if (line_i) begin
            run_d = '0;
        end else if (tick_i) begin
            if (run_q == BW'(BRK_TICKS)) hit_o = 1'b1;
            if (run_q <= BW'(BRK_TICKS)) run_d = run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R9: the hit pulse fires once per low run
    a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |=> !hit_o);
endmodule

// File: rtl/uartx_rx.sv
`timescale 1ns/1ps
module uartx_rx #(
    parameter int OS_RATE    = 16,
    parameter int LONG_FRAME = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic       nine_bit_i,
    input  logic       mp_i,
    input  logic       ext_en_i,
    input  logic       rxf_clr_i,
    input  logic       rd_i,
    output logic [7:0] data_o,
    output logic       bit9_o,
    output logic       rxf_o,
    output logic       ferr_o,
    output logic       berr_o,
    output logic       oerr_o
);
    import uartx_pkg::*;

    localparam int CW        = $clog2(OS_RATE);
    localparam int MID       = OS_RATE / 2;
    localparam int BRK_TICKS = LONG_FRAME * OS_RATE;

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [3:0]    idx;
        logic          s_a;
        logic          s_b;
        logic [8:0]    shf;
        logic          armed;
        logic [7:0]    data;
        logic          bit9;
        logic          rxf;
        logic          fe;
        logic          be;
        logic          oe;
    } rx_regs_t;

    rx_regs_t r_d, r_q;
    logic     rx_s;
    logic     brk_hit;
    logic     done;
    logic     stop_v;
    logic     vote;
    logic     accept;
    logic [3:0] last_idx;

    uartx_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    uartx_brk_det #(.BRK_TICKS(BRK_TICKS)) u_brk (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .line_i (rx_s),
        .hit_o  (brk_hit)
    );

    always_comb begin
        r_d      = r_q;
        done     = 1'b0;
        stop_v   = 1'b0;
        vote     = maj3(r_q.s_a, r_q.s_b, rx_s);
        last_idx = nine_bit_i ? 4'd9 : 4'd8;

        if (rxf_clr_i) r_d.rxf = 1'b0;
        if (rd_i)      r_d.oe  = 1'b0;

        if (tick_i) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (rx_s) begin
                        r_d.armed = 1'b1;
                    end else if (r_q.armed) begin
                        r_d.st    = ST_START;
                        r_d.cnt   = '0;
                        r_d.armed = 1'b0;
                        r_d.shf   = '0;
                    end
                end
                ST_START: begin
                    if (r_q.cnt == CW'(MID) && rx_s) begin
                        r_d.st    = ST_IDLE;
                        r_d.armed = 1'b1;
                    end else if (r_q.cnt == CW'(OS_RATE - 1)) begin
                        r_d.st  = ST_BITS;
                        r_d.cnt = '0;
                        r_d.idx = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_BITS: begin
                    if (r_q.cnt == CW'(MID - 1)) r_d.s_a = rx_s;
                    if (r_q.cnt == CW'(MID))     r_d.s_b = rx_s;
                    if (r_q.cnt == CW'(OS_RATE - 1)) begin
                        r_d.cnt = '0;
                        r_d.idx = r_q.idx + 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                    if (r_q.cnt == CW'(MID + 1)) begin
                        if (r_q.idx == last_idx) begin
                            done    = 1'b1;
                            stop_v  = vote;
                            r_d.st  = ST_IDLE;
                            r_d.cnt = '0;
                        end else begin
                            r_d.shf[r_q.idx] = vote;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end

        accept = ext_en_i ||
                 (!r_q.rxf && !(mp_i && !nine_bit_i && !stop_v));

        if (done && accept) begin
            r_d.data = r_q.shf[7:0];
            r_d.bit9 = nine_bit_i ? r_q.shf[8] : stop_v;
            r_d.rxf  = 1'b1;
            r_d.fe   = !stop_v;
            r_d.be   = 1'b0;
            r_d.oe   = r_d.oe | r_q.rxf;
        end

        if (brk_hit) r_d.be = 1'b1;

        if (!ext_en_i) begin
            r_d.fe = 1'b0;
            r_d.be = 1'b0;
            r_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o = r_q.data;
    assign bit9_o = r_q.bit9;
    assign rxf_o  = r_q.rxf;
    assign ferr_o = r_q.fe;
    assign berr_o = r_q.be;
    assign oerr_o = r_q.oe;

    // R4 / R11: completion only happens on a tick cycle
    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxf_o) |-> $past(tick_i));

    // R6: legacy behaviour keeps the held byte while the flag is up
    a_r6_legacy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en_i && rxf_o && !rxf_clr_i) |=> $stable(data_o));

    // R7: a frame error appears together with a stored character
    a_r7_fe_with_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr_o) |-> rxf_o);

    // R8: overwrite needs a pending character
    a_r8_oe_needs_rxf: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oerr_o) |-> $past(rxf_o));

    // R8: a read on a non-tick cycle leaves the overwrite flag low
    a_r8_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !tick_i) |=> !oerr_o);

    // R10: error flags stay low without the extended enable
    a_r10_flags_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en_i |=> (!ferr_o && !berr_o && !oerr_o));
endmodule

// File: tb/uartx_rx_bench.sv
`timescale 1ns/1ps
module uartx_rx_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic rx_i = 1'b1, tick_i = 1'b1;
    logic nine = 1'b0, mp = 1'b0, ext = 1'b0, clr = 1'b0, rd = 1'b0;
    logic [7:0] data_o;
    logic bit9_o, rxf_o, ferr_o, berr_o, oerr_o;

    int n_chk = 0, n_err = 0;
    bit tick_half = 0, tick_off = 0, finished = 0;

    uartx_rx u_uartx_rx (
        .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
        .nine_bit_i(nine), .mp_i(mp), .ext_en_i(ext),
        .rxf_clr_i(clr), .rd_i(rd),
        .data_o(data_o), .bit9_o(bit9_o), .rxf_o(rxf_o),
        .ferr_o(ferr_o), .berr_o(berr_o), .oerr_o(oerr_o)
    );

    always @(negedge clk)
        tick_i <= tick_off ? 1'b0 : (tick_half ? ~tick_i : 1'b1);

    // Behavioural reference, updated every rising edge
    int m_sh1, m_sh2, m_armed, m_phase, m_cnt, m_idx, m_s7, m_s8, m_low;
    bit [8:0] m_bits;
    int m_data, m_b9, m_rxf, m_fe, m_be, m_oe;

    always @(posedge clk) begin : mdl
        int rs, maj, stp, nrxf, nfe, nbe, noe;
        bit dn, brk, acc;
        if (!rst_n) begin
            m_sh1 = 1; m_sh2 = 1; m_armed = 0; m_phase = 0; m_cnt = 0;
            m_idx = 0; m_s7 = 0; m_s8 = 0; m_low = 0; m_bits = '0;
            m_data = 0; m_b9 = 0; m_rxf = 0; m_fe = 0; m_be = 0; m_oe = 0;
        end else begin
            rs = m_sh2; m_sh2 = m_sh1; m_sh1 = rx_i;
            dn = 0; brk = 0; stp = 0;
            nrxf = clr ? 0 : m_rxf;
            noe  = rd ? 0 : m_oe;
            nfe  = m_fe; nbe = m_be;
            if (rs == 1) m_low = 0;
            else if (tick_i) begin
                if (m_low == 176) brk = 1;
                if (m_low < 177) m_low++;
            end
            if (tick_i) begin
                if (m_phase == 0) begin
                    if (rs == 1) m_armed = 1;
                    else if (m_armed == 1) begin
                        m_phase = 1; m_cnt = 0; m_armed = 0; m_bits = '0;
                    end
                end else if (m_phase == 1) begin
                    if (m_cnt == 8 && rs == 1) begin m_phase = 0; m_armed = 1; end
                    else if (m_cnt == 15) begin m_phase = 2; m_cnt = 0; m_idx = 0; end
                    else m_cnt++;
                end else begin
                    if (m_cnt == 7) m_s7 = rs;
                    if (m_cnt == 8) m_s8 = rs;
                    if (m_cnt == 9) begin
                        maj = ((m_s7 + m_s8 + rs) >= 2) ? 1 : 0;
                        if (m_idx == (nine ? 9 : 8)) begin
                            dn = 1; stp = maj; m_phase = 0; m_cnt = 0;
                        end else m_bits[m_idx] = maj[0];
                    end
                    if (!dn) begin
                        if (m_cnt == 15) begin m_cnt = 0; m_idx++; end
                        else m_cnt++;
                    end
                end
            end
            acc = ext || (m_rxf == 0 && !(mp && !nine && stp == 0));
            if (dn && acc) begin
                m_data = m_bits[7:0];
                m_b9 = nine ? m_bits[8] : stp;
                nrxf = 1; nfe = (stp == 0); nbe = 0;
                noe = noe | m_rxf;
            end
            if (brk) nbe = 1;
            if (!ext) begin nfe = 0; nbe = 0; noe = 0; end
            m_rxf = nrxf; m_fe = nfe; m_be = nbe; m_oe = noe;
        end
    end

    // Clock-by-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_chk++;
            if (data_o !== 8'(m_data) || bit9_o !== m_b9[0] || rxf_o !== m_rxf[0] ||
                ferr_o !== m_fe[0] || berr_o !== m_be[0] || oerr_o !== m_oe[0]) begin
                n_err++;
                $display("FAIL R3/R5 model: data=%h bit9=%b exp %h %b", data_o, bit9_o, m_data[7:0], m_b9[0]);
                $display("FAIL R4/R7/R8/R9 model: rxf=%b fe=%b be=%b oe=%b exp %b %b %b %b",
                         rxf_o, ferr_o, berr_o, oerr_o, m_rxf[0], m_fe[0], m_be[0], m_oe[0]);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rx_i = v;
        end
    endtask

    task automatic send(input logic [8:0] d, input logic stp, input int cyc, input int gbit);
        int nb;
        nb = nine ? 9 : 8;
        hold(1'b0, cyc);
        for (int b = 0; b < nb; b++) begin
            for (int c = 0; c < cyc; c++) begin
                @(negedge clk);
                rx_i = (b == gbit && c == cyc / 2) ? ~d[b] : d[b];
            end
        end
        hold(stp, cyc);
        hold(1'b1, 2 * cyc);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd = 1'b1;
        @(negedge clk); rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", data_o, 0);
        chk("R1 flags", {bit9_o, rxf_o, ferr_o, berr_o, oerr_o}, 0);
        hold(1'b1, 20);

        // Legacy eight-bit reception
        send(9'h0A5, 1'b1, 16, -1);
        chk("R3 byte", data_o, 8'hA5);
        chk("R4 rxf set", rxf_o, 1);
        chk("R5 stop in bit9", bit9_o, 1);
        pulse_clr();
        chk("R4 rxf clear", rxf_o, 0);

        // Legacy: second character dropped while flag high
        send(9'h03C, 1'b1, 16, -1);
        send(9'h081, 1'b1, 16, -1);
        chk("R6 legacy keeps byte", data_o, 8'h3C);
        pulse_clr();

        // Multiprocessor drop of missing stop bit
        mp = 1'b1;
        send(9'h055, 1'b0, 16, -1);
        chk("R6 mp drop rxf", rxf_o, 0);
        chk("R6 mp drop data", data_o, 8'h3C);
        mp = 1'b0;
        send(9'h012, 1'b0, 16, -1);
        chk("R5 bit9 low stop", bit9_o, 0);
        chk("R10 legacy no fe", ferr_o, 0);
        pulse_clr();

        // Short start glitch
        hold(1'b0, 4);
        hold(1'b1, 40);
        chk("R2 glitch ignored", rxf_o, 0);
        send(9'h06E, 1'b1, 16, -1);
        chk("R2 after glitch", data_o, 8'h6E);
        pulse_clr();

        // Single-sample corruption mid-bit
        send(9'h0F0, 1'b1, 16, 0);
        chk("R3 vote bit0", data_o, 8'hF0);
        pulse_clr();
        send(9'h0F0, 1'b1, 16, 5);
        chk("R3 vote bit5", data_o, 8'hF0);
        pulse_clr();

        // Extended nine-bit
        ext = 1'b1; nine = 1'b1;
        hold(1'b1, 8);
        send(9'h1A5, 1'b1, 16, -1);
        chk("R5 ninth bit", bit9_o, 1);
        chk("R7 no fe", ferr_o, 0);
        send(9'h0C3, 1'b0, 16, -1);
        chk("R7 overwritten", data_o, 8'hC3);
        chk("R7 fe nine-bit", ferr_o, 1);
        chk("R8 oe set", oerr_o, 1);
        pulse_rd();
        chk("R8 oe cleared", oerr_o, 0);
        chk("R8 rxf kept", rxf_o, 1);
        pulse_clr();

        // Extended eight-bit frame error
        nine = 1'b0;
        hold(1'b1, 8);
        send(9'h077, 1'b0, 16, -1);
        chk("R7 fe eight-bit", ferr_o, 1);
        pulse_clr();

        // Break
        hold(1'b0, 200);
        hold(1'b1, 48);
        chk("R9 break flag", berr_o, 1);
        chk("R9 null byte", data_o, 0);
        pulse_clr();
        send(9'h05A, 1'b1, 16, -1);
        chk("R9 break cleared", berr_o, 0);
        chk("R9 next byte", data_o, 8'h5A);
        pulse_clr();

        // Disabling extended behaviour zeroes flags
        send(9'h000, 1'b0, 16, -1);
        chk("R7 fe set before off", ferr_o, 1);
        ext = 1'b0;
        hold(1'b1, 3);
        chk("R10 flags off", {ferr_o, berr_o, oerr_o}, 0);
        pulse_clr();

        // Half tick rate
        tick_half = 1;
        send(9'h09D, 1'b1, 32, -1);
        chk("R11 half rate", data_o, 8'h9D);
        tick_half = 0;
        pulse_clr();
        tick_off = 1;
        hold(1'b1, 4);
        hold(1'b0, 60);
        hold(1'b1, 10);
        tick_off = 0;
        hold(1'b1, 40);
        chk("R11 no tick no rx", rxf_o, 0);
        chk("R11 data kept", data_o, 8'h9D);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule